// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Controller

This block carries short messages between the two ports of a shared two-port memory. It watches each port's select, write strobe, output enable and word address. It holds two mailbox words at the top of the address space. The highest word belongs to the right port. The word just below it belongs to the left port.

When one port writes into the other port's mailbox, an active-low interrupt is raised to the mailbox owner. The owner clears that interrupt by reading its own mailbox. Each port also receives a busy flag from the external contention arbiter. While a port's busy flag is high, that port can neither raise the other side's interrupt nor clear its own. The contents of a message are defined by the user. They are stored as plain data and can be read back from either port.

The block is synchronous to one clock and uses an active-low reset. A port writes when `x_sel`=1 and `x_we`=1. A port reads when `x_sel`=1, `x_we`=0 and `x_oe`=1.

Top module: `mailbox_irq_ctrl`

## Requirements
- R1: After reset, `lt_irq_n` and `rt_irq_n` are both 1, and both mailbox words hold 0.
- R2: The right port's mailbox is at the all-ones address, 2^ADDR_W-1. The left port's mailbox is at 2^ADDR_W-2.
- R3: A write by one port into the other port's mailbox, made while the writer's busy input is 0, drives the owner's irq_n to 0 at the next clock edge.
- R4: A read by the owner of its own mailbox, made while the owner's busy input is 0, returns the owner's irq_n to 1 at the next clock edge.
- R5: A read of the other port's mailbox leaves both irq_n outputs unchanged. So does a mailbox access with `x_oe`=0 and `x_we`=0.
- R6: While a port's busy input is 1, its write into the other mailbox leaves the other irq_n unchanged.
- R7: While a port's busy input is 1, its read of its own mailbox leaves its irq_n unchanged.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends set (irq_n = 0).
- R9: A port writing its own mailbox updates that word but leaves both irq_n outputs unchanged.
- R10: Any mailbox write stores its data at the clock edge, whatever the busy inputs are. A port's `x_rdata` shows the addressed mailbox word in the same cycle as its read strobe, and shows 0 otherwise.
- R11: When both ports write one mailbox in the same cycle, the word keeps the non-owner's data.
- R12: Accesses to any address other than the two mailboxes change neither flag nor either mailbox word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lt_sel | input | 1 | Left port select |
| lt_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| lt_oe | input | 1 | Left output enable |
| lt_addr | input | ADDR_W | Left word address |
| lt_wdata | input | DATA_W | Left write data |
| lt_busy | input | 1 | Busy from the arbiter, applied to the left port |
| lt_irq_n | output | 1 | Active-low interrupt to the left port |
| lt_rdata | output | DATA_W | Mailbox read data for the left port |
| rt_sel | input | 1 | Right port select |
| rt_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| rt_oe | input | 1 | Right output enable |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | DATA_W | Right write data |
| rt_busy | input | 1 | Busy from the arbiter, applied to the right port |
| rt_irq_n | output | 1 | Active-low interrupt to the right port |
| rt_rdata | output | DATA_W | Mailbox read data for the right port |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. With only sixteen words, the two mailbox slots (14 and 15) are hit often under random addressing. This makes same-cycle set/clear collisions and dual writes to one mailbox common enough to occur many times per run. An 8-bit data width keeps the stored messages distinct. Directed steps come before the random run and cover each busy-gated case one at a time.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SIDE_LT = 0;
  localparam int SIDE_RT = 1;

  // Mailbox slot of a side: the right port owns the top word, the left the one below.
  function automatic logic [31:0] slot_addr(input int aw, input int side);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (side == SIDE_RT) ? top : top - 32'd1;
  endfunction

  // Flag update: a set dominates a clear in the same cycle.
  function automatic logic flag_next_n(input logic cur_n, input logic set, input logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur_n;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 15,
  parameter int SIDE   = 0
) (
  input  logic              sel,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              hit_own,
  output logic              hit_peer
);
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(mbx_pkg::slot_addr(ADDR_W, SIDE));
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(mbx_pkg::slot_addr(ADDR_W, 1 - SIDE));

  always_comb begin
    wr_stb   = sel & we;
    rd_stb   = sel & ~we & oe;
    hit_own  = (addr == OWN_A);
    hit_peer = (addr == PEER_A);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= mbx_pkg::flag_next_n(irq_n, set_evt, clr_evt);
  end

  // R3 / R8: a set event always leaves the flag active
  a_r8_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (irq_n == 1'b0));
  // R4: a lone clear releases the flag
  a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> (irq_n == 1'b1));
  // R5: no event, no change
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peer_wr,
  input  logic [DATA_W-1:0] peer_data,
  input  logic              own_wr,
  input  logic [DATA_W-1:0] own_data,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (peer_wr) word <= peer_data;
    else if (own_wr)  word <= own_data;
  end

  // R11: the non-owner's write wins a same-cycle collision
  a_r11_peer_priority: assert property (@(posedge clk) disable iff (!rst_n)
    peer_wr |=> (word == $past(peer_data)));
  // R9: the owner's own write lands when alone
  a_r9_own_write: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && !peer_wr) |=> (word == $past(own_data)));
  // R12: the word is untouched without a write
  a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_wr && !peer_wr) |=> $stable(word));
endmodule

// File: rtl/mailbox_irq_ctrl.sv
module mailbox_irq_ctrl #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_sel,
  input  logic              lt_we,
  input  logic              lt_oe,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic [DATA_W-1:0] lt_wdata,
  input  logic              lt_busy,
  output logic              lt_irq_n,
  output logic [DATA_W-1:0] lt_rdata,
  input  logic              rt_sel,
  input  logic              rt_we,
  input  logic              rt_oe,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [DATA_W-1:0] rt_wdata,
  input  logic              rt_busy,
  output logic              rt_irq_n,
  output logic [DATA_W-1:0] rt_rdata
);
  localparam int NSIDE = 2;

  // Per-side arrays: index 0 is the left port, 1 the right port.
  logic              sel_v   [NSIDE];
  logic              we_v    [NSIDE];
  logic              oe_v    [NSIDE];
  logic [ADDR_W-1:0] addr_v  [NSIDE];
  logic [DATA_W-1:0] wd_v    [NSIDE];
  logic              busy_v  [NSIDE];
  logic              wr_stb  [NSIDE];
  logic              rd_stb  [NSIDE];
  logic              hit_own [NSIDE];
  logic              hit_peer[NSIDE];
  logic              set_evt [NSIDE];
  logic              clr_evt [NSIDE];
  logic              irq_v   [NSIDE];
  logic [DATA_W-1:0] mb_word [NSIDE];
  logic [DATA_W-1:0] rd_v    [NSIDE];

  assign sel_v[0]  = lt_sel;    assign sel_v[1]  = rt_sel;
  assign we_v[0]   = lt_we;     assign we_v[1]   = rt_we;
  assign oe_v[0]   = lt_oe;     assign oe_v[1]   = rt_oe;
  assign addr_v[0] = lt_addr;   assign addr_v[1] = rt_addr;
  assign wd_v[0]   = lt_wdata;  assign wd_v[1]   = rt_wdata;
  assign busy_v[0] = lt_busy;   assign busy_v[1] = rt_busy;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int P = NSIDE - 1 - s;

    mbx_port_decode #(.ADDR_W(ADDR_W), .SIDE(s)) u_dec (
      .sel(sel_v[s]), .we(we_v[s]), .oe(oe_v[s]), .addr(addr_v[s]),
      .wr_stb(wr_stb[s]), .rd_stb(rd_stb[s]),
      .hit_own(hit_own[s]), .hit_peer(hit_peer[s])
    );

    // Set: the peer writes this side's mailbox and is not held off.
    // Clear: this side reads its own mailbox and is not held off.
    assign set_evt[s] = wr_stb[P] & hit_peer[P] & ~busy_v[P];
    assign clr_evt[s] = rd_stb[s] & hit_own[s] & ~busy_v[s];

    mbx_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_evt(set_evt[s]), .clr_evt(clr_evt[s]),
      .irq_n(irq_v[s])
    );

    mbx_store #(.DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .peer_wr(wr_stb[P] & hit_peer[P]), .peer_data(wd_v[P]),
      .own_wr(wr_stb[s] & hit_own[s]),   .own_data(wd_v[s]),
      .word(mb_word[s])
    );

    always_comb begin
      rd_v[s] = '0;
      if (rd_stb[s] && hit_own[s])       rd_v[s] = mb_word[s];
      else if (rd_stb[s] && hit_peer[s]) rd_v[s] = mb_word[P];
    end
  end

  assign lt_irq_n = irq_v[0];
  assign rt_irq_n = irq_v[1];
  assign lt_rdata = rd_v[0];
  assign rt_rdata = rd_v[1];

  // R3 / R6: the right flag can only fall after an unheld left write to the right mailbox
  a_r6_rt_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rt_irq_n) |-> $past(lt_sel && lt_we && (lt_addr == '1) && !lt_busy));
  // R3 / R6: the left flag can only fall after an unheld right write to the left mailbox
  a_r6_lt_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lt_irq_n) |-> $past(rt_sel && rt_we && (rt_addr == ADDR_W'(mbx_pkg::slot_addr(ADDR_W, 0))) && !rt_busy));
  // R4 / R7: the right flag rises only after an unheld right read of its own mailbox
  a_r7_rt_rise_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_irq_n) |-> $past(rt_sel && !rt_we && rt_oe && (rt_addr == '1) && !rt_busy));
  // R10: read data is zero whenever the port is not reading
  a_r10_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(lt_sel && !lt_we && lt_oe) |-> (lt_rdata == '0));
endmodule

// File: tb/sim_mailbox_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mailbox_irq_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] RMB = 4'd15;
  localparam logic [AW-1:0] LMB = 4'd14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_we = 0, l_oe = 0, l_busy = 0;
  logic r_sel = 0, r_we = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic l_irq_n, r_irq_n;
  logic [DW-1:0] l_rd, r_rd;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  // Bench model state
  logic m_lirq = 1'b1, m_rirq = 1'b1;
  logic [DW-1:0] m_lmb = '0, m_rmb = '0;

  always #2.5 clk = ~clk;

  mailbox_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lt_sel(l_sel), .lt_we(l_we), .lt_oe(l_oe), .lt_addr(l_addr), .lt_wdata(l_wd),
    .lt_busy(l_busy), .lt_irq_n(l_irq_n), .lt_rdata(l_rd),
    .rt_sel(r_sel), .rt_we(r_we), .rt_oe(r_oe), .rt_addr(r_addr), .rt_wdata(r_wd),
    .rt_busy(r_busy), .rt_irq_n(r_irq_n), .rt_rdata(r_rd)
  );

  function automatic logic [DW-1:0] exp_rd(input logic s, input logic w, input logic o,
                                            input logic [AW-1:0] a);
    if (!(s && !w && o)) return '0;
    if (a == RMB) return m_rmb;
    if (a == LMB) return m_lmb;
    return '0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Called just after a falling edge with the inputs set up.
  task automatic tick(input string tag);
    logic lw, rw, lr, rr, set_r, clr_r, set_l, clr_l;
    #0.5;
    chk(tag, "lt_rdata", int'(l_rd), int'(exp_rd(l_sel, l_we, l_oe, l_addr)));
    chk(tag, "rt_rdata", int'(r_rd), int'(exp_rd(r_sel, r_we, r_oe, r_addr)));
    lw = l_sel & l_we;  lr = l_sel & ~l_we & l_oe;
    rw = r_sel & r_we;  rr = r_sel & ~r_we & r_oe;
    set_r = lw && l_addr == RMB && !l_busy;
    clr_r = rr && r_addr == RMB && !r_busy;
    set_l = rw && r_addr == LMB && !r_busy;
    clr_l = lr && l_addr == LMB && !l_busy;
    m_rirq = set_r ? 1'b0 : (clr_r ? 1'b1 : m_rirq);
    m_lirq = set_l ? 1'b0 : (clr_l ? 1'b1 : m_lirq);
    if (lw && l_addr == RMB)      m_rmb = l_wd;
    else if (rw && r_addr == RMB) m_rmb = r_wd;
    if (rw && r_addr == LMB)      m_lmb = r_wd;
    else if (lw && l_addr == LMB) m_lmb = l_wd;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "lt_irq_n", int'(l_irq_n), int'(m_lirq));
    chk(tag, "rt_irq_n", int'(r_irq_n), int'(m_rirq));
  endtask

  task automatic drv_l(input logic s, input logic w, input logic o, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic b);
    l_sel = s; l_we = w; l_oe = o; l_addr = a; l_wd = d; l_busy = b;
  endtask

  task automatic drv_r(input logic s, input logic w, input logic o, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic b);
    r_sel = s; r_we = w; r_oe = o; r_addr = a; r_wd = d; r_busy = b;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2816));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "lt_irq_n", int'(l_irq_n), 1);
    chk("R1", "rt_irq_n", int'(r_irq_n), 1);
    rst_n = 1'b1;
    drv_l(1, 0, 1, RMB, 0, 0); drv_r(1, 0, 1, LMB, 0, 1);   // busy read of peer mailbox
    tick("R1");
    // R2 R3: left writes the top word, right flag falls
    drv_l(1, 1, 0, RMB, 8'hA5, 0); drv_r(0, 0, 0, 0, 0, 0);
    tick("R3");
    // R5: peer-mailbox reads and oe-less access leave flags alone
    drv_l(1, 0, 1, RMB, 0, 0); drv_r(1, 0, 1, LMB, 0, 0);
    tick("R5");
    drv_l(0, 0, 0, 0, 0, 0); drv_r(1, 0, 0, RMB, 0, 0);
    tick("R5");
    // R7: busy owner read does not clear
    drv_r(1, 0, 1, RMB, 0, 1);
    tick("R7");
    // R4: owner read clears
    drv_r(1, 0, 1, RMB, 0, 0);
    tick("R4");
    // R6 R10: busy write stores data but raises nothing
    drv_l(1, 1, 0, RMB, 8'h3C, 1); drv_r(0, 0, 0, 0, 0, 0);
    tick("R6");
    drv_l(0, 0, 0, 0, 0, 0); drv_r(1, 0, 1, RMB, 0, 1);
    tick("R10");
    // R2 R3: right writes the word below the top, left flag falls
    drv_r(1, 1, 0, LMB, 8'h77, 0);
    tick("R2");
    // R9: owner writes its own mailbox, no flag change
    drv_r(1, 1, 0, RMB, 8'h99, 0);
    tick("R9");
    drv_r(1, 0, 1, RMB, 0, 0);
    tick("R9");
    // R8: set and clear of the right flag together
    drv_l(1, 1, 0, RMB, 8'h5A, 0); drv_r(1, 0, 1, RMB, 0, 0);
    tick("R8");
    // R11: both write the right mailbox, left data kept
    drv_l(1, 1, 0, RMB, 8'h11, 0); drv_r(1, 1, 0, RMB, 8'h22, 0);
    tick("R11");
    drv_l(1, 0, 1, RMB, 0, 0); drv_r(1, 0, 1, LMB, 0, 0);
    tick("R11");
    // R12: other addresses change nothing
    drv_l(1, 1, 0, 4'd3, 8'hEE, 0); drv_r(1, 0, 1, 4'd0, 0, 0);
    tick("R12");
    drv_l(1, 0, 1, LMB, 0, 0); drv_r(1, 1, 0, 4'd13, 8'hDD, 0);
    tick("R12");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] la, ra;
      la = ($urandom_range(0, 3) != 0) ? ($urandom_range(0, 1) ? RMB : LMB) : AW'($urandom);
      ra = ($urandom_range(0, 3) != 0) ? ($urandom_range(0, 1) ? RMB : LMB) : AW'($urandom);
      drv_l(1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), la, DW'($urandom),
            1'($urandom_range(0, 3) == 0));
      drv_r(1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), ra, DW'($urandom),
            1'($urandom_range(0, 3) == 0));
      tick("R3/R4/R6/R7/R8 random");
    end
    finish_run();
  end
endmodule